// File: doc/BRIEF.md
# Serial SAR Converter Interface Model

This block is a synthesizable slave-side model of the digital interface of a 10-bit serial successive-approximation converter. A host drives an active-low chip select, a frame sync, an I/O clock and a serial command line. The model answers on a serial output that has a separate drive enable, and it reports conversion activity on an end-of-conversion flag. All interface inputs are sampled in the system clock domain. The I/O clock and the frame sync act on their falling edges, which the block detects from one registered copy of each input.

Each frame does two jobs at once. On the first four I/O clock falling edges a 4-bit command is shifted in, MSB first. Over the same edges the result of the previous conversion is shifted out, MSB first, and zeros follow it for the rest of a 16-clock frame. On the tenth falling edge the command is acted on. A channel or self-test command latches its value and starts a conversion that lasts a programmable number of system clocks. A rate, power-down or reserved command changes no result. Analog inputs are modelled by a parallel test bus that carries one 10-bit value per channel.

Top module: `sar_link_model`

## Requirements
- R1: After reset, eoc is 1, sdo_oe is 0, sdo is 0, the stored result is 000h and the conversion rate is fast.
- R2: While cs_n is 1, sdo_oe is 0 and fs, ioclk and sdi have no effect. No conversion starts, eoc stays 1 when no conversion is running, and the stored result is unchanged.
- R3: While cs_n is 0 and no frame has begun, sdo_oe is 1 and sdo is 0.
- R4: A frame begins on a falling edge of fs while cs_n is 0 and eoc is 1. The previous result's bit 9-k is on sdo after k ioclk falling edges (k = 0..9). sdi is captured on the first four falling edges as command bits 3 down to 0.
- R5: A conversion starts on the tenth ioclk falling edge. eoc is 0 for exactly FAST_CYC system clocks (fast rate) or SLOW_CYC system clocks (slow rate), and the new result is stored when eoc returns to 1.
- R6: Commands 0h to 7h convert a channel value. With NUM_CH = 4, command bits [2:1] select the channel, so 0h/2h/4h/6h pick channels 0..3 and each odd code picks the same channel as the even code below it. With NUM_CH = 8, bits [2:0] select the channel.
- R7: Self-test commands Bh, Ch and Dh give the results 200h, 000h and 3FFh.
- R8: Commands 8h (power-down), 9h (fast rate), Ah (slow rate), Eh and Fh start no conversion and keep the stored result. 9h and Ah set the rate used by later conversions.
- R9: On falling edges 10 to 15 of a frame, sdo is 0.
- R10: If cs_n rises before the tenth falling edge, the frame ends with no conversion, no rate change and no change of result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| fs | input | 1 | Frame sync; a frame begins on its falling edge |
| ioclk | input | 1 | Serial I/O clock, acted on at falling edges |
| sdi | input | 1 | Serial command input |
| chan_val | input | NUM_CH*RES_W | Test value per channel, channel 0 in the low bits |
| sdo | output | 1 | Serial result output |
| sdo_oe | output | 1 | Drive enable for sdo (0 = high impedance) |
| eoc | output | 1 | End of conversion, low while converting |

## Verification
The bench goes after the one-frame lag between command and result. A design that output the current frame's command result, instead of the previous one, would show the wrong value on every frame. It checks the odd channel codes on the four-input variant, where a design using the low command bits would return a neighbour channel. It checks that a rate command changes the length of later conversions but starts no conversion itself, and that bits 10 to 15 are zero rather than leftovers of the shift register. It also runs a frame with chip select released after six edges, and a full burst of edges with chip select high. Either would start a spurious conversion and overwrite the result if the frame were not cut off.

// File: rtl/sar_link_pkg.sv
// Package: shared constants for the serial converter interface model.
// Assumes a 4-bit command word; codes above 7h are non-channel commands.
package sar_link_pkg;
    localparam int CMD_W = 4;
    localparam logic [CMD_W-1:0] CMD_PWRDN  = 4'h8;
    localparam logic [CMD_W-1:0] CMD_FAST   = 4'h9;
    localparam logic [CMD_W-1:0] CMD_SLOW   = 4'hA;
    localparam logic [CMD_W-1:0] CMD_TST_MID = 4'hB;
    localparam logic [CMD_W-1:0] CMD_TST_LO = 4'hC;
    localparam logic [CMD_W-1:0] CMD_TST_HI = 4'hD;
endpackage

// File: rtl/sar_edge_fall.sv
// Module: falling-edge detector for a slow input sampled by the system clock.
// Assumes the input is already synchronous to clk (no metastability stage).
module sar_edge_fall (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic fall
);
    logic sig_q;

    // Hold last sampled level of the input.
    always_ff @(posedge clk) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig;
    end

    // Edge when the previous level was high and the present one is low.
    always_comb fall = sig_q & ~sig;
endmodule

// File: rtl/sar_cmd_decode.sv
// Module: decodes a 4-bit command into conversion request, rate change and value.
// Assumes NUM_CH is 4 or 8; the four-input variant uses command bits [2:1].
module sar_cmd_decode
    import sar_link_pkg::*;
#(
    parameter int RES_W  = 10,
    parameter int NUM_CH = 4
) (
    input  logic [CMD_W-1:0]        cmd,
    input  logic [NUM_CH*RES_W-1:0] chan_val,
    output logic                    conv_req,
    output logic                    set_fast,
    output logic                    set_slow,
    output logic [RES_W-1:0]        val
);
    localparam int CH_W = (NUM_CH == 4) ? 2 : 3;
    localparam logic [RES_W-1:0] MID_CODE = RES_W'(1) << (RES_W - 1);

    logic [CH_W-1:0] ch_idx;

    // Channel index picked by the variant.
    generate
        if (NUM_CH == 4) begin : g_four
            assign ch_idx = cmd[2:1];
        end else begin : g_eight
            assign ch_idx = cmd[2:0];
        end
    endgenerate

    // Map the command to its action and result value.
    always_comb begin
        conv_req = 1'b0;
        set_fast = 1'b0;
        set_slow = 1'b0;
        val      = '0;
        case (cmd)
            CMD_PWRDN:   ;
            CMD_FAST:    set_fast = 1'b1;
            CMD_SLOW:    set_slow = 1'b1;
            CMD_TST_MID: begin conv_req = 1'b1; val = MID_CODE; end
            CMD_TST_LO:  begin conv_req = 1'b1; val = '0; end
            CMD_TST_HI:  begin conv_req = 1'b1; val = '1; end
            4'hE, 4'hF:  ;
            default: begin
                conv_req = 1'b1;
                val      = chan_val[ch_idx*RES_W +: RES_W];
            end
        endcase
    end
endmodule

// File: rtl/sar_conv_timer.sv
// Module: conversion timer; busy for FAST_CYC or SLOW_CYC clocks after start.
// Assumes start is only raised while idle; both lengths are at least 1.
module sar_conv_timer #(
    parameter int FAST_CYC = 40,
    parameter int SLOW_CYC = 160
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic slow,
    output logic busy,
    output logic done
);
    localparam int MAX_CYC = (SLOW_CYC > FAST_CYC) ? SLOW_CYC : FAST_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;

    // Load the length on start, count down to zero, then go idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= slow ? CNT_W'(SLOW_CYC - 1) : CNT_W'(FAST_CYC - 1);
        end else if (busy_q) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end
    end

    // Outputs: busy level and last-cycle pulse.
    always_comb begin
        busy = busy_q;
        done = busy_q && (cnt_q == '0);
    end

    // R5: a conversion never restarts while one is running.
    assert_start_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy_q);
    // R5: the down-counter stays inside the programmed length.
    assert_cnt_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt_q < CNT_W'(MAX_CYC)));
endmodule

// File: rtl/sar_link_model.sv
// Module: slave model of a 10-bit serial converter interface. Shifts out the
// previous result while a 4-bit command shifts in, then converts on edge 10.
// Assumes all inputs are synchronous to clk and ioclk is much slower than clk.
module sar_link_model
    import sar_link_pkg::*;
#(
    parameter int RES_W      = 10,
    parameter int NUM_CH     = 4,
    parameter int FRAME_CLKS = 16,
    parameter int FAST_CYC   = 40,
    parameter int SLOW_CYC   = 160
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cs_n,
    input  logic                    fs,
    input  logic                    ioclk,
    input  logic                    sdi,
    input  logic [NUM_CH*RES_W-1:0] chan_val,
    output logic                    sdo,
    output logic                    sdo_oe,
    output logic                    eoc
);
    localparam int CNT_W = $clog2(FRAME_CLKS + 1);

    logic             io_fall, fs_fall;
    logic             in_frame;
    logic [CNT_W-1:0] edge_cnt;
    logic [RES_W-1:0] shreg, result_q, conv_val_q, dec_val;
    logic [CMD_W-1:0] cmd_q;
    logic             slow_q;
    logic             conv_req, set_fast, set_slow;
    logic             busy, done;
    logic             frame_start, frame_edge, hold_edge, conv_start;

    sar_edge_fall i_io_edge (.clk(clk), .rst_n(rst_n), .sig(ioclk), .fall(io_fall));
    sar_edge_fall i_fs_edge (.clk(clk), .rst_n(rst_n), .sig(fs),    .fall(fs_fall));

    sar_cmd_decode #(.RES_W(RES_W), .NUM_CH(NUM_CH)) i_decode (
        .cmd(cmd_q), .chan_val(chan_val), .conv_req(conv_req),
        .set_fast(set_fast), .set_slow(set_slow), .val(dec_val)
    );

    sar_conv_timer #(.FAST_CYC(FAST_CYC), .SLOW_CYC(SLOW_CYC)) i_timer (
        .clk(clk), .rst_n(rst_n), .start(conv_start), .slow(slow_q),
        .busy(busy), .done(done)
    );

    // Frame events derived from the detected edges.
    always_comb begin
        frame_start = fs_fall && !cs_n && !busy;
        frame_edge  = in_frame && !cs_n && io_fall && (edge_cnt < CNT_W'(FRAME_CLKS));
        hold_edge   = frame_edge && (edge_cnt == CNT_W'(RES_W - 1));
        conv_start  = hold_edge && conv_req;
    end

    // Frame state, shift register and command capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame <= 1'b0;
            edge_cnt <= '0;
            shreg    <= '0;
            cmd_q    <= '0;
        end else if (cs_n) begin
            in_frame <= 1'b0;
        end else if (frame_start) begin
            in_frame <= 1'b1;
            edge_cnt <= '0;
            shreg    <= result_q;
        end else if (frame_edge) begin
            edge_cnt <= edge_cnt + 1'b1;
            shreg    <= {shreg[RES_W-2:0], 1'b0};
            if (edge_cnt < CNT_W'(CMD_W)) cmd_q <= {cmd_q[CMD_W-2:0], sdi};
        end
    end

    // Rate mode and held sample, updated at the hold edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slow_q     <= 1'b0;
            conv_val_q <= '0;
        end else if (hold_edge) begin
            if (conv_req) conv_val_q <= dec_val;
            if (set_fast) slow_q <= 1'b0;
            if (set_slow) slow_q <= 1'b1;
        end
    end

    // Result store, written as the conversion ends.
    always_ff @(posedge clk) begin
        if (!rst_n)    result_q <= '0;
        else if (done) result_q <= conv_val_q;
    end

    // Pin drivers.
    always_comb begin
        sdo_oe = !cs_n;
        sdo    = (!cs_n && in_frame) ? shreg[RES_W-1] : 1'b0;
        eoc    = !busy;
    end

    // R9: after the result bits the shift register carries only zeros.
    assert_pad_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_frame && (edge_cnt >= CNT_W'(RES_W))) |-> (shreg == '0));
    // R4: a frame loads the stored result of the previous conversion.
    assert_load_prev_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (shreg == $past(result_q)));
    // R5: eoc only falls right after a tenth falling edge.
    assert_eoc_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eoc) |-> $past(hold_edge));
    // R2: deselection ends any frame.
    assert_deselect_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !in_frame);
endmodule

// File: tb/test_sar_link_model.sv
module test_sar_link_model;
    localparam int CLK_PERIOD = 10;
    localparam int RES_W  = 10;
    localparam int NUM_CH = 4;
    localparam int FAST   = 30;
    localparam int SLOW   = 90;
    localparam int NVEC   = 16;

    // Command, result it produces, and whether it converts.
    localparam logic [3:0] VEC_CMD [NVEC] = '{4'h0, 4'h2, 4'h4, 4'h6, 4'h1, 4'h7, 4'hB, 4'hC,
                                               4'hD, 4'hA, 4'h4, 4'h8, 4'h9, 4'h2, 4'hE, 4'hF};
    localparam logic [9:0] VEC_RES [NVEC] = '{10'h155, 10'h2AA, 10'h0F0, 10'h30C, 10'h155, 10'h30C,
                                               10'h200, 10'h000, 10'h3FF, 10'h3FF, 10'h0F0, 10'h0F0,
                                               10'h0F0, 10'h2AA, 10'h2AA, 10'h2AA};
    localparam logic       VEC_CNV [NVEC] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1,
                                               1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};

    logic clk = 1'b0;
    logic rst_n, cs_n, fs, ioclk, sdi;
    logic [NUM_CH*RES_W-1:0] chan_val;
    logic sdo, sdo_oe, eoc;

    int  n_cmp = 0;
    int  n_bad = 0;
    int  low_cnt = 0;
    bit  finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sar_link_model #(.RES_W(RES_W), .NUM_CH(NUM_CH), .FRAME_CLKS(16),
                     .FAST_CYC(FAST), .SLOW_CYC(SLOW)) i_sar_link_model (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .fs(fs), .ioclk(ioclk), .sdi(sdi),
        .chan_val(chan_val), .sdo(sdo), .sdo_oe(sdo_oe), .eoc(eoc)
    );

    // Count system clocks with eoc low.
    always @(negedge clk) if (rst_n && !eoc) low_cnt++;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One frame with nedges ioclk falling edges; returns the 16 sdo samples.
    task automatic run_frame(input logic [3:0] cmd, input int nedges,
                             output logic [15:0] bits, output logic eoc10);
        bits  = '0;
        eoc10 = 1'b1;
        cs_n = 1'b0;
        tick(3);
        chk("R3", "sdo_oe before fs", int'(sdo_oe), 1);
        chk("R3", "sdo before fs", int'(sdo), 0);
        fs = 1'b1; tick(2); fs = 1'b0; tick(2);
        bits[15] = sdo;
        for (int i = 0; i < nedges; i++) begin
            sdi = (i < 4) ? cmd[3-i] : 1'b0;
            ioclk = 1'b1; tick(2);
            ioclk = 1'b0; tick(2);
            if (i < 15) bits[14-i] = sdo;
            if (i == 9) eoc10 = eoc;
        end
        tick(1);
        cs_n = 1'b1;
        sdi  = 1'b0;
    endtask

    task automatic wait_eoc();
        int guard = 0;
        while (!eoc && guard < 2000) begin tick(1); guard++; end
    endtask

    function automatic string tag_of(input logic [3:0] c);
        if (c < 4'h8) return "R6";
        if (c >= 4'hB && c <= 4'hD) return "R7";
        return "R8";
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog R5: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] bits;
        logic        e10;
        logic [9:0]  prev;
        string       prev_tag;
        bit          slow_exp;

        chan_val = {10'h30C, 10'h0F0, 10'h2AA, 10'h155};
        rst_n = 1'b0; cs_n = 1'b1; fs = 1'b0; ioclk = 1'b0; sdi = 1'b0;
        tick(5);
        rst_n = 1'b1;
        tick(2);
        // R1: reset state at the pins
        chk("R1", "eoc after reset", int'(eoc), 1);
        chk("R1", "sdo_oe after reset", int'(sdo_oe), 0);
        chk("R1", "sdo after reset", int'(sdo), 0);

        prev = 10'h000;       // R1: first result is 000h
        prev_tag = "R1";
        slow_exp = 1'b0;      // R1: fast rate after reset

        for (int v = 0; v < NVEC; v++) begin
            low_cnt = 0;
            run_frame(VEC_CMD[v], 16, bits, e10);
            chk(prev_tag, "result bits (R4 order)", int'(bits[15:6]), int'(prev));
            chk("R9", "padding bits", int'(bits[5:0]), 0);
            wait_eoc();
            if (VEC_CNV[v]) begin
                chk("R5", "eoc at edge 10", int'(e10), 0);
                chk("R5", "conversion length", low_cnt, slow_exp ? SLOW : FAST);
            end else begin
                chk("R8", "no conversion", low_cnt, 0);
            end
            if (VEC_CMD[v] == 4'hA) slow_exp = 1'b1;
            if (VEC_CMD[v] == 4'h9) slow_exp = 1'b0;
            prev = VEC_RES[v];
            prev_tag = tag_of(VEC_CMD[v]);
            tick(3);
        end

        // R2: with cs_n high a full burst of fs and ioclk is ignored
        low_cnt = 0;
        fs = 1'b1; tick(2); fs = 1'b0; tick(2);
        for (int i = 0; i < 16; i++) begin
            sdi = (i < 4) ? 1'b1 : 1'b0;    // command Fh pattern, then Dh would differ
            ioclk = 1'b1; tick(2);
            chk("R2", "sdo_oe while deselected", int'(sdo_oe), 0);
            ioclk = 1'b0; tick(2);
        end
        sdi = 1'b0;
        chk("R2", "eoc while deselected", int'(eoc), 1);
        chk("R2", "no conversion while deselected", low_cnt, 0);

        // Frame 0h: result must still be the last one (R2)
        low_cnt = 0;
        run_frame(4'h0, 16, bits, e10);
        chk("R2", "result kept while deselected", int'(bits[15:6]), int'(prev));
        wait_eoc();
        chk("R5", "fast length after 9h", low_cnt, FAST);
        prev = 10'h155;
        tick(3);

        // R10: cs_n rises after six edges with command 6h
        low_cnt = 0;
        run_frame(4'h6, 6, bits, e10);
        tick(4);
        chk("R10", "no conversion on short frame", low_cnt, 0);
        chk("R10", "eoc after short frame", int'(eoc), 1);
        tick(3);

        low_cnt = 0;
        run_frame(4'hC, 16, bits, e10);
        chk("R10", "result after short frame", int'(bits[15:6]), int'(prev));
        wait_eoc();
        tick(3);

        run_frame(4'hE, 16, bits, e10);
        chk("R7", "self-test low code", int'(bits[15:6]), 0);
        chk("R9", "padding after self-test", int'(bits[5:0]), 0);
        tick(3);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule